// File: doc/BRIEF.md
# Redundant Energy Frame Receiver

This block takes serial energy frames from two redundant links, called A and B. Each link has a sampled bit input and a strobe. For each link the block searches the bit stream for a fixed header. It then gathers the payload, which holds a 16-bit energy value, a toggle nibble and a 4-bit check code, and tests the check code. Every link keeps three counters: completed frames, check failures and missed frame windows. Each link also runs two watchdogs. One measures the time since the last good frame. The other measures the time since the energy value last changed.

From the links that are currently healthy, the block picks one energy value. It translates that value into a 5-bit code and drives the code to the threshold logic downstream. If both links have missed their frame window, the block stops trusting either one. It drives the highest code and raises an error flag. A link whose errors are frequent but not yet fatal raises a per-link warning, and the output keeps running from the other link.

All time windows are given in clock cycles. At 250 MHz, the default values match a 1 ms frame period and a 1 s stale and rate window.

Top module: `dual_energy_rx`

## Requirements
- R1: A frame starts once the last eight strobed bits equal 8'b1001_0000. The next 24 strobed bits are then taken MSB first as: energy[15:0], toggle, three pad bits, check[3:0]. Bits that do not complete a header, and words whose header is different, produce no frame.
- R2: The check code is a 4-bit CRC with polynomial x^4+x+1 and initial value zero. It is computed MSB first over the 20 bits made of the energy field, the toggle bit and the pad bits. A frame whose CRC does not match increments that link's CRC-error counter. Such a frame never updates the stored energy value.
- R3: Each completed frame, good or bad, increments that link's frame counter by exactly one.
- R4: A good frame is accepted as a new energy value only when its toggle bit differs from the toggle of the last accepted frame. The first good frame after reset is always accepted.
- R5: If LOST_CYCLES cycles pass without a good frame, the link's lost flag sets and its lost counter increments. The counter increments again for each further empty window. A good frame clears the lost flag.
- R6: If STALE_CYCLES cycles pass without an accepted value, the link's stale flag sets. Accepting a value clears it. A link is usable when it holds a value and is neither lost nor stale.
- R7: The breakpoints are bp(i) = 64*i*i for i = 0..31. The code is the largest i with bp(i) <= value. For example, 1599 gives 4, 1600 gives 5, 61503 gives 30 and 65535 gives 31.
- R8: When link A is usable it drives the code and the source flag is 0. When only link B is usable, B drives the code and the source flag is 1. The code appears one cycle after the link state.
- R9: When both lost flags are set, the code is forced to 31 and the error flag is 1 from the next cycle on. At all other times the error flag is 0.
- R10: When neither link is usable and they are not both lost, the code keeps its last value.
- R11: A link's error events are its CRC failures and its lost-window events. Within one WARN_WINDOW period, the link's warning sets on the event that brings the count above WARN_LIMIT. It clears when the window restarts.
- R12: After reset the code is 0, the error and source flags are 0, no link is usable, lost, stale or warning, and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lnk_bit | input | 2 | Sampled serial data, bit 0 link A, bit 1 link B |
| lnk_stb | input | 2 | Per-link strobe marking a valid data bit |
| energy_code | output | 5 | Selected 5-bit energy code |
| energy_err | output | 1 | Set when both links are lost (code forced to 31) |
| src_b | output | 1 | 1 when link B supplied the code |
| link_ok | output | 2 | Per-link usable flag |
| link_lost | output | 2 | Per-link lost-frame flag |
| link_stale | output | 2 | Per-link stale-value flag |
| link_warn | output | 2 | Per-link error-rate warning |
| frame_cnt | output | 2xCNT_W | Per-link completed-frame counters |
| crc_err_cnt | output | 2xCNT_W | Per-link CRC-error counters |
| lost_cnt | output | 2xCNT_W | Per-link lost-window counters |

## Verification
The bench puts noise bits and a near-miss header ahead of real frames. A receiver that locks onto partial patterns would count frames that were never sent. It repeats toggle bits to show that repeated frames are counted but leave the value alone. A design that ignores the toggle would track the new energy. It also sends corrupted frames carrying different energies, and a design that latches before the CRC test would move the code. The bench starves one link, then both, then only the value of one link and then of the other. A design with wrong priority would fall back to the stale A value. A design that forgot the hold rule would drift, and one with a wrong force rule would miss 31 with the error flag. The breakpoint edges and the exact third error that trips the warning expose off-by-one comparisons.

// File: rtl/efr_pkg.sv
package efr_pkg;

    localparam logic [7:0] SYNC_WORD  = 8'b1001_0000;
    localparam int         PAYLOAD_W  = 24;
    localparam int         VALUE_W    = 16;
    localparam int         CODE_W     = 5;
    localparam int         N_CODES    = 1 << CODE_W;
    localparam int         BP_SCALE   = 64;

    typedef enum logic {
        ST_SEEK,
        ST_PAYLOAD
    } rx_state_e;

    typedef struct packed {
        logic [VALUE_W-1:0] value;
        logic               tog;
        logic               good;
    } frame_t;

    // CRC over x^4 + x + 1, zero seed, MSB first
    function automatic logic [3:0] crc4_calc(input logic [19:0] data);
        logic [3:0] c;
        logic       fb;
        c = 4'h0;
        for (int k = 19; k >= 0; k--) begin
            fb = data[k] ^ c[3];
            c  = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
        end
        return c;
    endfunction

    // Ascending breakpoint for code index idx
    function automatic logic [16:0] breakpoint(input int idx);
        return 17'(BP_SCALE * idx * idx);
    endfunction

endpackage

// File: rtl/frame_deser.sv
module frame_deser
    import efr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ser_bit,
    input  logic   ser_stb,
    output logic   done,
    output frame_t frm
);

    localparam int CNT_W = $clog2(PAYLOAD_W);

    rx_state_e            state;
    logic [7:0]           sync_sr;
    logic [PAYLOAD_W-1:0] pay_sr;
    logic [CNT_W-1:0]     bit_idx;
    logic [7:0]           sync_nxt;
    logic [PAYLOAD_W-1:0] pay_nxt;
    logic                 crc_match;

    always_comb begin
        sync_nxt  = {sync_sr[6:0], ser_bit};
        pay_nxt   = {pay_sr[PAYLOAD_W-2:0], ser_bit};
        crc_match = (crc4_calc(pay_nxt[23:4]) == pay_nxt[3:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_SEEK;
            sync_sr <= '0;
            pay_sr  <= '0;
            bit_idx <= '0;
            done    <= 1'b0;
            frm     <= '0;
        end else begin
            done <= 1'b0;
            if (ser_stb) begin
                case (state)
                    ST_SEEK: begin
                        sync_sr <= sync_nxt;
                        if (sync_nxt == SYNC_WORD) begin
                            state   <= ST_PAYLOAD;
                            bit_idx <= '0;
                        end
                    end
                    ST_PAYLOAD: begin
                        pay_sr <= pay_nxt;
                        if (bit_idx == CNT_W'(PAYLOAD_W - 1)) begin
                            state     <= ST_SEEK;
                            sync_sr   <= '0;
                            done      <= 1'b1;
                            frm.value <= pay_nxt[23:8];
                            frm.tog   <= pay_nxt[7];
                            frm.good  <= crc_match;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    default: state <= ST_SEEK;
                endcase
            end
        end
    end

endmodule

// File: rtl/link_monitor.sv
module link_monitor
    import efr_pkg::*;
#(
    parameter int LOST_CYCLES  = 250_000,
    parameter int STALE_CYCLES = 250_000_000,
    parameter int WARN_WINDOW  = 250_000_000,
    parameter int WARN_LIMIT   = 10,
    parameter int CNT_W        = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  frame_t             frm,
    output logic [VALUE_W-1:0] value,
    output logic               ok,
    output logic               lost,
    output logic               stale,
    output logic               warn,
    output logic [CNT_W-1:0]   frame_cnt,
    output logic [CNT_W-1:0]   crc_cnt,
    output logic [CNT_W-1:0]   lost_cnt
);

    localparam int GAP_W  = $clog2(LOST_CYCLES + 1);
    localparam int AGE_W  = $clog2(STALE_CYCLES + 1);
    localparam int WIN_W  = $clog2(WARN_WINDOW + 1);
    localparam int ERR_W  = $clog2(WARN_LIMIT + 2);

    logic [GAP_W-1:0] gap_t;
    logic [AGE_W-1:0] age_t;
    logic [WIN_W-1:0] win_t;
    logic [ERR_W-1:0] err_n;
    logic             have_val;
    logic             last_tog;
    logic             good_frm;
    logic             bad_frm;
    logic             lost_evt;
    logic             take;
    logic             win_end;
    logic             err_evt;

    always_comb begin
        good_frm = done && frm.good;
        bad_frm  = done && !frm.good;
        lost_evt = !good_frm && (gap_t == GAP_W'(LOST_CYCLES - 1));
        take     = good_frm && (!have_val || (frm.tog != last_tog));
        win_end  = (win_t == WIN_W'(WARN_WINDOW - 1));
        err_evt  = bad_frm || lost_evt;
        ok       = have_val && !lost && !stale;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_t     <= '0;
            age_t     <= '0;
            win_t     <= '0;
            err_n     <= '0;
            have_val  <= 1'b0;
            last_tog  <= 1'b0;
            value     <= '0;
            lost      <= 1'b0;
            stale     <= 1'b0;
            warn      <= 1'b0;
            frame_cnt <= '0;
            crc_cnt   <= '0;
            lost_cnt  <= '0;
        end else begin
            if (done)     frame_cnt <= frame_cnt + 1'b1;
            if (bad_frm)  crc_cnt   <= crc_cnt + 1'b1;
            if (lost_evt) lost_cnt  <= lost_cnt + 1'b1;

            // frame window watchdog
            if (good_frm || lost_evt) gap_t <= '0;
            else                      gap_t <= gap_t + 1'b1;
            if (good_frm)      lost <= 1'b0;
            else if (lost_evt) lost <= 1'b1;

            // value freshness watchdog
            if (take) begin
                have_val <= 1'b1;
                last_tog <= frm.tog;
                value    <= frm.value;
                age_t    <= '0;
                stale    <= 1'b0;
            end else if (age_t == AGE_W'(STALE_CYCLES - 1)) begin
                stale <= 1'b1;
            end else begin
                age_t <= age_t + 1'b1;
            end

            // error-rate window
            if (win_end) begin
                win_t <= '0;
                err_n <= '0;
                warn  <= 1'b0;
            end else begin
                win_t <= win_t + 1'b1;
                if (err_evt) begin
                    if (err_n <= ERR_W'(WARN_LIMIT)) err_n <= err_n + 1'b1;
                    if (err_n >= ERR_W'(WARN_LIMIT)) warn  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/energy_map.sv
module energy_map
    import efr_pkg::*;
(
    input  logic [VALUE_W-1:0] value,
    output logic [CODE_W-1:0]  code
);

    logic [N_CODES-1:1] at_or_above;

    for (genvar i = 1; i < N_CODES; i++) begin : g_cmp
        assign at_or_above[i] = ({1'b0, value} >= breakpoint(i));
    end

    always_comb begin
        code = '0;
        for (int i = 1; i < N_CODES; i++) begin
            if (at_or_above[i]) code = CODE_W'(i);
        end
    end

endmodule

// File: rtl/dual_energy_rx.sv
module dual_energy_rx
    import efr_pkg::*;
#(
    parameter int LOST_CYCLES  = 250_000,
    parameter int STALE_CYCLES = 250_000_000,
    parameter int WARN_WINDOW  = 250_000_000,
    parameter int WARN_LIMIT   = 10,
    parameter int CNT_W        = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             lnk_bit,
    input  logic [1:0]             lnk_stb,
    output logic [4:0]             energy_code,
    output logic                   energy_err,
    output logic                   src_b,
    output logic [1:0]             link_ok,
    output logic [1:0]             link_lost,
    output logic [1:0]             link_stale,
    output logic [1:0]             link_warn,
    output logic [1:0][CNT_W-1:0]  frame_cnt,
    output logic [1:0][CNT_W-1:0]  crc_err_cnt,
    output logic [1:0][CNT_W-1:0]  lost_cnt
);

    localparam int N_LINKS = 2;

    logic [N_LINKS-1:0]              frm_done;
    frame_t                          frm [N_LINKS];
    logic [N_LINKS-1:0][VALUE_W-1:0] lnk_value;
    logic [VALUE_W-1:0]              pick_value;
    logic [CODE_W-1:0]               pick_code;
    logic [CODE_W-1:0]               code_nxt;
    logic                            err_nxt;
    logic                            src_nxt;

    for (genvar i = 0; i < N_LINKS; i++) begin : g_link
        frame_deser deser_i (
            .clk     (clk),
            .rst     (rst),
            .ser_bit (lnk_bit[i]),
            .ser_stb (lnk_stb[i]),
            .done    (frm_done[i]),
            .frm     (frm[i])
        );

        link_monitor #(
            .LOST_CYCLES  (LOST_CYCLES),
            .STALE_CYCLES (STALE_CYCLES),
            .WARN_WINDOW  (WARN_WINDOW),
            .WARN_LIMIT   (WARN_LIMIT),
            .CNT_W        (CNT_W)
        ) mon_i (
            .clk       (clk),
            .rst       (rst),
            .done      (frm_done[i]),
            .frm       (frm[i]),
            .value     (lnk_value[i]),
            .ok        (link_ok[i]),
            .lost      (link_lost[i]),
            .stale     (link_stale[i]),
            .warn      (link_warn[i]),
            .frame_cnt (frame_cnt[i]),
            .crc_cnt   (crc_err_cnt[i]),
            .lost_cnt  (lost_cnt[i])
        );
    end

    assign pick_value = link_ok[0] ? lnk_value[0] : lnk_value[1];

    energy_map map_i (
        .value (pick_value),
        .code  (pick_code)
    );

    always_comb begin
        code_nxt = energy_code;
        err_nxt  = 1'b0;
        src_nxt  = src_b;
        if (&link_lost) begin
            code_nxt = CODE_W'(N_CODES - 1);
            err_nxt  = 1'b1;
        end else if (link_ok[0]) begin
            code_nxt = pick_code;
            src_nxt  = 1'b0;
        end else if (link_ok[1]) begin
            code_nxt = pick_code;
            src_nxt  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            energy_code <= '0;
            energy_err  <= 1'b0;
            src_b       <= 1'b0;
        end else begin
            energy_code <= code_nxt;
            energy_err  <= err_nxt;
            src_b       <= src_nxt;
        end
    end

endmodule

// File: rtl/dual_energy_rx_chk.sv
module dual_energy_rx_chk #(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [4:0]            energy_code,
    input logic                  energy_err,
    input logic                  src_b,
    input logic [1:0]            link_ok,
    input logic [1:0]            link_lost,
    input logic [1:0][CNT_W-1:0] frame_cnt
);

    // R9
    both_lost_force_chk: assert property (@(posedge clk) disable iff (rst)
        (link_lost == 2'b11) |=> (energy_code == 5'd31 && energy_err));

    // R9
    err_only_when_lost_chk: assert property (@(posedge clk) disable iff (rst)
        energy_err |-> $past(link_lost == 2'b11));

    // R8
    prefer_a_chk: assert property (@(posedge clk) disable iff (rst)
        (link_ok[0] && link_lost != 2'b11) |=> (!src_b && !energy_err));

    // R8
    fallback_b_chk: assert property (@(posedge clk) disable iff (rst)
        (link_ok == 2'b10 && link_lost != 2'b11) |=> src_b);

    // R10
    hold_code_chk: assert property (@(posedge clk) disable iff (rst)
        (link_ok == 2'b00 && link_lost != 2'b11) |=> $stable(energy_code));

    for (genvar i = 0; i < 2; i++) begin : g_cnt
        // R3
        frame_step_chk: assert property (@(posedge clk) disable iff (rst)
            (frame_cnt[i] != $past(frame_cnt[i])) |->
            (frame_cnt[i] == $past(frame_cnt[i]) + 1'b1));
    end

endmodule

bind dual_energy_rx dual_energy_rx_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .energy_code (energy_code),
    .energy_err  (energy_err),
    .src_b       (src_b),
    .link_ok     (link_ok),
    .link_lost   (link_lost),
    .frame_cnt   (frame_cnt)
);

// File: tb/dual_energy_rx_tb_top.sv
module dual_energy_rx_tb_top;

    localparam int LOST  = 200;
    localparam int STALE = 2000;
    localparam int WIN   = 3000;
    localparam int LIM   = 2;
    localparam int CW    = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [1:0]          lnk_bit = '0;
    logic [1:0]          lnk_stb = '0;
    logic [4:0]          energy_code;
    logic                energy_err;
    logic                src_b;
    logic [1:0]          link_ok, link_lost, link_stale, link_warn;
    logic [1:0][CW-1:0]  frame_cnt, crc_err_cnt, lost_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit all_done = 1'b0;

    always #2 clk = ~clk;

    dual_energy_rx #(
        .LOST_CYCLES (LOST), .STALE_CYCLES (STALE),
        .WARN_WINDOW (WIN), .WARN_LIMIT (LIM), .CNT_W (CW)
    ) dut_i (
        .clk (clk), .rst (rst), .lnk_bit (lnk_bit), .lnk_stb (lnk_stb),
        .energy_code (energy_code), .energy_err (energy_err), .src_b (src_b),
        .link_ok (link_ok), .link_lost (link_lost), .link_stale (link_stale),
        .link_warn (link_warn), .frame_cnt (frame_cnt),
        .crc_err_cnt (crc_err_cnt), .lost_cnt (lost_cnt)
    );

    function automatic logic [3:0] ref_crc(input logic [19:0] d);
        logic [3:0] c = 4'h0;
        logic fb;
        for (int k = 19; k >= 0; k--) begin
            fb = d[k] ^ c[3];
            c  = {c[2:0], 1'b0} ^ {2'b00, fb, fb};
        end
        return c;
    endfunction

    function automatic logic [31:0] mk(input logic [15:0] v, input logic t, input bit bad);
        logic [19:0] body = {v, t, 3'b000};
        logic [3:0]  c    = ref_crc(body);
        if (bad) c = ~c;
        return {8'h90, body, c};
    endfunction

    function automatic logic [4:0] ref_code(input int v);
        logic [4:0] r = '0;
        for (int i = 0; i < 32; i++) if (64 * i * i <= v) r = 5'(i);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; lnk_stb = '0; lnk_bit = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_pair(input logic [31:0] fa, input bit ea,
                             input logic [31:0] fb, input bit eb);
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk);
            lnk_bit = {fb[i], fa[i]};
            lnk_stb = {eb, ea};
            @(negedge clk);
            lnk_stb = '0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R12 reset state
    task automatic t_reset();
        do_reset();
        check("R12 code", energy_code, 0);
        check("R12 err", energy_err, 0);
        check("R12 src", src_b, 0);
        check("R12 ok", link_ok, 0);
        check("R12 lost", link_lost, 0);
        check("R12 stale", link_stale, 0);
        check("R12 warn", link_warn, 0);
        check("R12 counters", frame_cnt[0] + frame_cnt[1] + crc_err_cnt[0] + lost_cnt[1], 0);
    endtask

    // R1 framing, R7 breakpoints, R8 preference
    task automatic t_map();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); lnk_bit = (i == 2) ? 2'b00 : 2'b11; lnk_stb = 2'b11;
            @(negedge clk); lnk_stb = '0;
        end
        send_pair(mk(16'd1600, 1'b1, 1'b0), 1'b1, mk(16'd40000, 1'b1, 1'b0), 1'b1);
        check("R1 frame after noise", frame_cnt[0], 1);
        check("R7 code 1600", energy_code, 5);
        check("R8 A preferred", src_b, 0);
        send_pair(32'h91FF_FFFF, 1'b1, 32'h91FF_FFFF, 1'b1);
        check("R1 bad header ignored", frame_cnt[0], 1);
        send_pair(mk(16'd1599, 1'b0, 1'b0), 1'b1, mk(16'd1599, 1'b0, 1'b0), 1'b1);
        check("R7 code 1599", energy_code, ref_code(1599));
        send_pair(mk(16'd61503, 1'b1, 1'b0), 1'b1, mk(16'd61503, 1'b1, 1'b0), 1'b1);
        check("R7 code 61503", energy_code, 30);
        send_pair(mk(16'hFFFF, 1'b0, 1'b0), 1'b1, mk(16'hFFFF, 1'b0, 1'b0), 1'b1);
        check("R7 code 65535", energy_code, 31);
        check("R9 no err when fed", energy_err, 0);
        send_pair(mk(16'd0, 1'b1, 1'b0), 1'b1, mk(16'd0, 1'b1, 1'b0), 1'b1);
        check("R7 code 0", energy_code, 0);
    endtask

    // R4 toggle rule
    task automatic t_toggle();
        do_reset();
        send_pair(mk(16'd3000, 1'b0, 1'b0), 1'b1, mk(16'd3000, 1'b0, 1'b0), 1'b1);
        check("R4 first accepted", energy_code, ref_code(3000));
        send_pair(mk(16'd20000, 1'b0, 1'b0), 1'b1, mk(16'd20000, 1'b0, 1'b0), 1'b1);
        check("R4 repeat toggle ignored", energy_code, ref_code(3000));
        check("R3 repeat counted", frame_cnt[0], 2);
        send_pair(mk(16'd20000, 1'b1, 1'b0), 1'b1, mk(16'd20000, 1'b1, 1'b0), 1'b1);
        check("R4 new toggle taken", energy_code, ref_code(20000));
    endtask

    // R2 CRC, R11 warning
    task automatic t_crc_warn();
        do_reset();
        send_pair(mk(16'd5000, 1'b1, 1'b0), 1'b1, mk(16'd9000, 1'b1, 1'b0), 1'b1);
        send_pair(mk(16'd50000, 1'b0, 1'b1), 1'b1, mk(16'd9000, 1'b0, 1'b0), 1'b1);
        check("R2 bad frame no update", energy_code, ref_code(5000));
        check("R2 crc count", crc_err_cnt[0], 1);
        send_pair(mk(16'd5000, 1'b1, 1'b0), 1'b1, mk(16'd9000, 1'b1, 1'b0), 1'b1);
        send_pair(mk(16'd50000, 1'b0, 1'b1), 1'b1, mk(16'd9000, 1'b0, 1'b0), 1'b1);
        check("R11 no warn at limit", link_warn, 0);
        send_pair(mk(16'd5000, 1'b1, 1'b0), 1'b1, mk(16'd9000, 1'b1, 1'b0), 1'b1);
        send_pair(mk(16'd50000, 1'b0, 1'b1), 1'b1, mk(16'd9000, 1'b0, 1'b0), 1'b1);
        check("R11 warn on A only", link_warn, 2'b01);
        check("R2 crc count 3", crc_err_cnt[0], 3);
        check("R3 frames 6", frame_cnt[0], 6);
        check("R2 B clean", crc_err_cnt[1], 0);
        idle(WIN);
        check("R11 warn cleared by window", link_warn[0], 0);
    endtask

    // R5 lost, R8 fallback, R9 force
    task automatic t_lost();
        do_reset();
        send_pair(mk(16'd2000, 1'b1, 1'b0), 1'b1, mk(16'd30000, 1'b1, 1'b0), 1'b1);
        for (int i = 0; i < 5; i++)
            send_pair(32'h0, 1'b0, mk(16'd30000, 1'(i), 1'b0), 1'b1);
        check("R5 A lost", link_lost, 2'b01);
        check("R5 A lost count", int'(lost_cnt[0] != 0), 1);
        check("R8 B used", src_b, 1);
        check("R8 B code", energy_code, ref_code(30000));
        check("R9 single lost no err", energy_err, 0);
        idle(LOST + 20);
        check("R9 both lost code", energy_code, 31);
        check("R9 both lost err", energy_err, 1);
        send_pair(mk(16'd2000, 1'b0, 1'b0), 1'b1, mk(16'd30000, 1'b1, 1'b0), 1'b1);
        check("R5 lost cleared", link_lost, 0);
        check("R9 err cleared", energy_err, 0);
        check("R8 A back", energy_code, ref_code(2000));
    endtask

    // R6 stale, R10 hold
    task automatic t_stale();
        do_reset();
        send_pair(mk(16'd7000, 1'b1, 1'b0), 1'b1, mk(16'd45000, 1'b1, 1'b0), 1'b1);
        check("R6 fresh A", energy_code, ref_code(7000));
        for (int i = 0; i < 30; i++)
            send_pair(mk(16'd7000, 1'b1, 1'b0), 1'b1, mk(16'd45000, 1'(i), 1'b0), 1'b1);
        check("R6 A stale", link_stale, 2'b01);
        check("R6 B code", energy_code, ref_code(45000));
        check("R6 src B", src_b, 1);
        for (int i = 0; i < 30; i++)
            send_pair(mk(16'd7000, 1'b1, 1'b0), 1'b1, mk(16'd45000, 1'b1, 1'b0), 1'b1);
        check("R10 both stale", link_ok, 0);
        check("R10 code held", energy_code, ref_code(45000));
        check("R10 no err", energy_err, 0);
        send_pair(mk(16'd7000, 1'b0, 1'b0), 1'b1, mk(16'd45000, 1'b1, 1'b0), 1'b1);
        check("R6 stale cleared", link_stale[0], 0);
        check("R6 A again", energy_code, ref_code(7000));
    endtask

    initial begin
        t_reset();
        t_map();
        t_toggle();
        t_crc_warn();
        t_lost();
        t_stale();
        all_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule